// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Controller

This block is a serial peripheral port that moves one byte at a time. A CPU reaches it through three byte-wide registers: a control register, a status register and a data register. In master mode the block makes its own serial clock from a divider on the system clock. It shifts the byte out on `mosi_o` and captures the reply on `miso_i`. In slave mode it follows an external serial clock while its select input is low. It shifts in from `mosi_i` and drives `miso_o`, and it releases that pin whenever it is not selected.

Clock polarity, clock phase and bit order can each be set, so all four clock modes are supported with either bit order. At the end of every byte the block sets a completion flag, which can raise an interrupt. Writing the data register during a transfer sets a collision flag. If a master sees its select input pulled low, it falls back to slave mode. Both flags clear when software reads the status register while a flag is set and then accesses the data register.

Top module: `spi_port`

## Requirements
- R1: After reset, the control and status registers read 0x00, `irq_o` is low and `miso_oe_o` is low.
- R2: The control register is at address 0 and reads back as written. Its bits from 7 down to 0 are: irq enable, port enable, lsb-first, master, clock polarity, clock phase, rate bit 1, rate bit 0. The status register is at address 1 and the data register is at address 2.
- R3: In the status register, bit 7 is the completion flag and bit 6 is the collision flag. Bits 5 to 1 always read 0. Bit 0 is the double-speed bit and is the only status bit a write can change.
- R4: With lsb-first set, bit 0 of the byte goes out first and the first bit received lands in bit 0. With lsb-first clear, bit 7 goes first in both directions.
- R5: The serial clock rests at the polarity bit. A master transfer makes exactly 8 leading and 8 trailing edges and ends at the rest level. With phase 0, data is sampled on leading edges and changed on trailing edges. With phase 1, it is the other way round.
- R6: In master mode the clock period is the system clock divided by 4, 16, 64 or 128 for rate values 0 to 3 with double speed off. With double speed on, the divisors are 2, 8, 32 and 64. Edges are evenly spaced at half that period.
- R7: Writing the data register while enabled, in master mode and idle starts a transfer. The completion flag sets when it ends. Reading the data register returns the last byte received.
- R8: `irq_o` is high exactly when the completion flag and the irq-enable bit are both set. A pulse on `irq_ack_i` clears the completion flag.
- R9: In master mode with the port enabled, a low select input clears the master bit and sets the completion flag.
- R10: A data-register write during a transfer sets the collision flag. The byte in flight is not changed.
- R11: A status read that sees a flag set, followed by any data-register access, clears both flags. A data-register access with no such status read before it leaves the flags unchanged.
- R12: In slave mode, bytes are shifted on the external clock while the select input is low, and the rate bits have no effect. A high select input resets the bit count. `miso_oe_o` is high only while the block is enabled as a slave and selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for the current address |
| irq_o | output | 1 | Interrupt request |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears the completion flag |
| sck_o | output | 1 | Serial clock driven in master mode |
| mosi_o | output | 1 | Serial data out in master mode |
| miso_i | input | 1 | Serial data in for master mode |
| sck_i | input | 1 | External serial clock for slave mode |
| mosi_i | input | 1 | Serial data in for slave mode |
| ss_ni | input | 1 | Select input, active low |
| miso_o | output | 1 | Serial data out for slave mode |
| miso_oe_o | output | 1 | Output enable for `miso_o` |

## Verification
The properties take it that the bus makes at most one access per cycle and never raises read and write together. They also take it that `ss_ni` stays high in master mode except when a mode fault is provoked on purpose, and that an external clock half period lasts at least four system clocks so the input synchronizer can follow it. The stimulus keeps to these limits. It changes pins only on falling clock edges, holds the select high through the master sweep, which covers every mode, order and rate, and drives slave transfers with four-cycle half periods.

// File: rtl/spi_port_pkg.sv
`timescale 1ns/1ps
package spi_port_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2
  } reg_addr_e;

  typedef struct packed {
    logic       irq_en;
    logic       enable;
    logic       lsb_first;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctrl_t;

endpackage

// File: rtl/spi_port_sync.sv
`timescale 1ns/1ps
module spi_port_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/spi_port_clkgen.sv
`timescale 1ns/1ps
module spi_port_clkgen #(
  parameter int unsigned HALF_LOG_MAX = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       fast_i,
  input  logic [1:0] rate_i,
  output logic       tick_o
);

  localparam int unsigned CNT_W = HALF_LOG_MAX + 1;

  logic [2:0]       lg_base, lg;
  logic [CNT_W-1:0] limit, cnt_q;

  // half period = 2^lg system clocks
  always_comb begin
    lg_base = (rate_i == 2'd3) ? 3'(HALF_LOG_MAX) : {rate_i, 1'b1};
    lg      = lg_base - {2'b00, fast_i};
    limit   = (CNT_W'(1) << lg) - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i)          cnt_q <= '0;
    else if (cnt_q == limit)  cnt_q <= '0;
    else                      cnt_q <= cnt_q + CNT_W'(1);
  end

  assign tick_o = run_i && (cnt_q == limit);

endmodule

// File: rtl/spi_port_shift.sv
`timescale 1ns/1ps
module spi_port_shift #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lsb_first_i,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  input  logic          preset_i,
  input  logic          sample_i,
  input  logic          setup_i,
  input  logic          din_i,
  output logic [DW-1:0] data_o,
  output logic [DW-1:0] shifted_o,
  output logic          out_o
);

  logic [DW-1:0] sh_q;
  logic          out_q;

  function automatic logic head_bit(input logic lsb, input logic [DW-1:0] v);
    return lsb ? v[0] : v[DW-1];
  endfunction

  assign shifted_o = lsb_first_i ? {din_i, sh_q[DW-1:1]} : {sh_q[DW-2:0], din_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      out_q <= 1'b0;
    end else if (load_i) begin
      sh_q  <= load_data_i;
      out_q <= head_bit(lsb_first_i, load_data_i);
    end else begin
      if (sample_i)            sh_q  <= shifted_o;
      if (setup_i || preset_i) out_q <= head_bit(lsb_first_i, sh_q);
    end
  end

  assign data_o = sh_q;
  assign out_o  = out_q;

endmodule

// File: rtl/spi_port.sv
`timescale 1ns/1ps
module spi_port import spi_port_pkg::*; #(
  parameter int unsigned DW           = 8,  // >= 8, register bytes sit in the low bits
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned HALF_LOG_MAX = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  input  logic          irq_ack_i,
  output logic          sck_o,
  output logic          mosi_o,
  input  logic          miso_i,
  input  logic          sck_i,
  input  logic          mosi_i,
  input  logic          ss_ni,
  output logic          miso_o,
  output logic          miso_oe_o
);

  localparam int unsigned BIT_W  = $clog2(DW);
  localparam int unsigned EDGE_W = $clog2(2 * DW);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * DW - 1);
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(DW - 1);

  ctrl_t             ctrl_q;
  logic              spif_q, wcol_q, fast_q, arm_q;
  logic [DW-1:0]     rx_q;
  logic              busy_q, sck_q;
  logic [EDGE_W-1:0] edge_q;
  logic [BIT_W-1:0]  sbit_q;
  logic              sck_s, mosi_s, ss_s, sck_d;

  spi_port_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b001)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, mosi_i, ss_ni}),
    .q_o   ({sck_s, mosi_s, ss_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_d <= 1'b0;
    else         sck_d <= sck_s;
  end

  // bus decode
  logic wr_ctrl, wr_stat, rd_stat, acc_data, wr_data;
  assign wr_ctrl  = wr_i && (addr_i == REG_CTRL);
  assign wr_stat  = wr_i && (addr_i == REG_STAT);
  assign rd_stat  = rd_i && (addr_i == REG_STAT);
  assign acc_data = (wr_i || rd_i) && (addr_i == REG_DATA);
  assign wr_data  = wr_i && (addr_i == REG_DATA);

  logic master_on, slave_on, slave_sel, fault;
  assign master_on = ctrl_q.enable && ctrl_q.master;
  assign slave_on  = ctrl_q.enable && !ctrl_q.master;
  assign slave_sel = slave_on && !ss_s;
  assign fault     = master_on && !ss_s;

  logic tick;
  spi_port_clkgen #(.HALF_LOG_MAX(HALF_LOG_MAX)) u_clkgen (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy_q),
    .fast_i(fast_q),
    .rate_i(ctrl_q.rate),
    .tick_o(tick)
  );

  // edge events, master from divider, slave from synchronized pin
  logic m_lead, m_trail, s_rise, s_fall, s_lead, s_trail, lead, trail;
  logic sample_ev, setup_ev;
  assign m_lead   = busy_q && tick && !edge_q[0];
  assign m_trail  = busy_q && tick &&  edge_q[0];
  assign s_rise   = sck_s && !sck_d;
  assign s_fall   = !sck_s && sck_d;
  assign s_lead   = slave_sel && (ctrl_q.cpol ? s_fall : s_rise);
  assign s_trail  = slave_sel && (ctrl_q.cpol ? s_rise : s_fall);
  assign lead     = master_on ? m_lead  : s_lead;
  assign trail    = master_on ? m_trail : s_trail;
  assign sample_ev = ctrl_q.cpha ? trail : lead;
  assign setup_ev  = ctrl_q.cpha ? lead  : trail;

  logic in_flight, busy_any, collide, start, load;
  assign in_flight = slave_sel && (sbit_q != '0);
  assign busy_any  = (master_on && busy_q) || in_flight;
  assign collide   = wr_data && busy_any;
  assign start     = wr_data && master_on && !busy_q && !fault;
  assign load      = wr_data && !busy_any;

  logic m_done, s_done, done;
  assign m_done = busy_q && tick && (edge_q == LAST_EDGE);
  assign s_done = slave_sel && sample_ev && (sbit_q == LAST_BIT);
  assign done   = m_done || s_done;

  logic [DW-1:0] sh_data, sh_next;
  logic          sh_out;
  spi_port_shift #(.DW(DW)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lsb_first_i(ctrl_q.lsb_first),
    .load_i     (load),
    .load_data_i(wdata_i),
    .preset_i   (slave_on && ss_s),
    .sample_i   (sample_ev),
    .setup_i    (setup_ev),
    .din_i      (master_on ? miso_i : mosi_s),
    .data_o     (sh_data),
    .shifted_o  (sh_next),
    .out_o      (sh_out)
  );

  // master sequencer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      edge_q <= '0;
      sck_q  <= 1'b0;
    end else if (!master_on || fault) begin
      busy_q <= 1'b0;
      edge_q <= '0;
      sck_q  <= ctrl_q.cpol;
    end else if (start) begin
      busy_q <= 1'b1;
      edge_q <= '0;
      sck_q  <= ctrl_q.cpol;
    end else if (busy_q && tick) begin
      sck_q  <= !sck_q;
      edge_q <= edge_q + EDGE_W'(1);
      if (edge_q == LAST_EDGE) busy_q <= 1'b0;
    end
  end

  // slave bit count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                sbit_q <= '0;
    else if (!slave_sel)        sbit_q <= '0;
    else if (sample_ev)         sbit_q <= (sbit_q == LAST_BIT) ? '0 : sbit_q + BIT_W'(1);
  end

  // registers and flags
  logic flag_clr;
  assign flag_clr = arm_q && acc_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      fast_q <= 1'b0;
      spif_q <= 1'b0;
      wcol_q <= 1'b0;
      arm_q  <= 1'b0;
      rx_q   <= '0;
    end else begin
      if (wr_ctrl)    ctrl_q <= ctrl_t'(wdata_i[7:0]);
      else if (fault) ctrl_q.master <= 1'b0;
      if (wr_stat)    fast_q <= wdata_i[0];
      spif_q <= done || fault || (spif_q && !flag_clr && !irq_ack_i);
      wcol_q <= collide || (wcol_q && !flag_clr);
      if (acc_data)                      arm_q <= 1'b0;
      else if (rd_stat && (spif_q || wcol_q)) arm_q <= 1'b1;
      if (done) rx_q <= sample_ev ? sh_next : sh_data;
    end
  end

  always_comb begin
    unique case (addr_i)
      REG_CTRL: rdata_o = DW'(ctrl_q);
      REG_STAT: rdata_o = DW'({spif_q, wcol_q, 5'b00000, fast_q});
      REG_DATA: rdata_o = rx_q;
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o     = spif_q && ctrl_q.irq_en;
  assign sck_o     = (master_on && busy_q) ? sck_q : ctrl_q.cpol;
  assign mosi_o    = sh_out;
  assign miso_o    = sh_out;
  assign miso_oe_o = slave_sel;

endmodule

// File: rtl/spi_port_chk.sv
`timescale 1ns/1ps
module spi_port_chk import spi_port_pkg::*; #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    addr_i,
  input logic          wr_i,
  input logic [DW-1:0] rdata_o,
  input logic          irq_o,
  input logic          sck_o,
  input logic          ss_ni,
  input logic          miso_oe_o,
  input ctrl_t         ctrl_i,
  input logic          busy_i,
  input logic          ss_sync_i,
  input logic          spif_i,
  input logic          wcol_i
);

  assert_rsvd_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == REG_STAT) |-> (rdata_o[5:1] == 5'b00000));

  assert_idle_level_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_i) && ctrl_i.enable && ctrl_i.master) |-> (sck_o == ctrl_i.cpol));

  assert_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == REG_DATA && ctrl_i.enable && ctrl_i.master && !busy_i && ss_sync_i)
      |=> busy_i);

  assert_irq_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ctrl_i.irq_en);

  assert_mode_fault_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.enable && ctrl_i.master && !ss_sync_i && !(wr_i && addr_i == REG_CTRL))
      |=> (!ctrl_i.master && spif_i));

  assert_collision_src_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wcol_i) |-> $past(wr_i && addr_i == REG_DATA));

  assert_miso_release_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_ni && $past(ss_ni) && $past(ss_ni, 2)) |-> !miso_oe_o);

endmodule

bind spi_port spi_port_chk #(.DW(DW)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wr_i     (wr_i),
  .rdata_o  (rdata_o),
  .irq_o    (irq_o),
  .sck_o    (sck_o),
  .ss_ni    (ss_ni),
  .miso_oe_o(miso_oe_o),
  .ctrl_i   (ctrl_q),
  .busy_i   (busy_q),
  .ss_sync_i(ss_s),
  .spif_i   (spif_q),
  .wcol_i   (wcol_q)
);

// File: tb/spi_port_tb_top.sv
`timescale 1ns/1ps
module spi_port_tb_top;

  localparam int unsigned DW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    addr_i = '0;
  logic          wr_i = 1'b0, rd_i = 1'b0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          irq_o, irq_ack_i = 1'b0;
  logic          sck_o, mosi_o, miso_i = 1'b0;
  logic          sck_i = 1'b0, mosi_i = 1'b0, ss_ni = 1'b1;
  logic          miso_o, miso_oe_o;

  always #4 clk_i = ~clk_i;

  spi_port #(.DW(DW)) dut_i (.*);

  int vectors = 0, misses = 0, cyc = 0;
  bit done_flag = 0;

  always @(negedge clk_i) cyc++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i); addr_i = a; rd_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk_i); rd_i = 1'b0;
  endtask

  // peer model for master transfers
  bit          peer_en = 0;
  logic        p_cpha, p_dord;
  logic [7:0]  peer_tx, peer_rx;
  int          pe, ps, exp_h, last_cyc, bad_gap;

  function automatic int bpos(input logic dord, input int i);
    return dord ? i : 7 - i;
  endfunction

  always @(sck_o) begin
    if (peer_en) begin
      if ((pe % 2 == 0) ^ p_cpha) begin
        if (ps < 8) peer_rx[bpos(p_dord, ps)] = mosi_o;
        ps++;
      end else if (ps < 8) begin
        miso_i = peer_tx[bpos(p_dord, ps)];
      end
      if (pe > 0 && (cyc - last_cyc) != exp_h) bad_gap++;
      last_cyc = cyc;
      pe++;
    end
  end

  function automatic int half_of(input logic fast, input logic [1:0] r);
    int div;
    case ({fast, r})
      3'b000: div = 4;   3'b001: div = 16;
      3'b010: div = 64;  3'b011: div = 128;
      3'b100: div = 2;   3'b101: div = 8;
      3'b110: div = 32;  default: div = 64;
    endcase
    return div / 2;
  endfunction

  task automatic wait_irq(input int limit);
    int w = 0;
    while (!irq_o && w < limit) begin @(negedge clk_i); w++; end
  endtask

  task automatic arm_peer(input logic cpha, input logic dord, input logic [7:0] ptx, input int h);
    p_cpha = cpha; p_dord = dord; peer_tx = ptx; peer_rx = '0;
    pe = 0; ps = 0; bad_gap = 0; exp_h = h;
    miso_i = ptx[bpos(dord, 0)];
    peer_en = 1;
  endtask

  task automatic slave_xfer(input logic cpol, input logic cpha, input logic dord,
                            input logic [7:0] mtx, input int nbits, output logic [7:0] mrx);
    mrx = '0;
    for (int i = 0; i < nbits; i++) begin
      int p = bpos(dord, i);
      if (!cpha) begin
        mosi_i = mtx[p]; wait_cyc(4); mrx[p] = miso_o;
        sck_i = ~cpol; wait_cyc(4); sck_i = cpol;
      end else begin
        sck_i = ~cpol; mosi_i = mtx[p]; wait_cyc(4); mrx[p] = miso_o;
        sck_i = cpol; wait_cyc(4);
      end
    end
  endtask

  initial begin : main
    logic [7:0] d, tx, ptx, mrx;
    rst_ni = 1'b0;
    wait_cyc(3);
    rst_ni = 1'b1;
    wait_cyc(2);

    // R1 reset state
    rd_reg(2'd0, d); chk("R1 ctrl", d, 8'h00);
    rd_reg(2'd1, d); chk("R1 stat", d, 8'h00);
    chk("R1 irq", irq_o, 1'b0);
    chk("R1 oe", miso_oe_o, 1'b0);

    // R2 control readback (port disabled)
    wr_reg(2'd0, 8'hA5); rd_reg(2'd0, d); chk("R2 ctrl A5", d, 8'hA5);
    wr_reg(2'd0, 8'h9A); rd_reg(2'd0, d); chk("R2 ctrl 9A", d, 8'h9A);
    wr_reg(2'd0, 8'h00);

    // R3 status writable bit
    wr_reg(2'd1, 8'hFF); rd_reg(2'd1, d); chk("R3 stat wr ff", d, 8'h01);
    wr_reg(2'd1, 8'h00); rd_reg(2'd1, d); chk("R3 stat wr 00", d, 8'h00);

    // R4 R5 R6 R7 R11: sweep modes, order and rates in master mode
    for (int v = 0; v < 64; v++) begin
      logic cpol, cpha, dord, fast;
      logic [1:0] r;
      {fast, r, dord, cpha, cpol} = 6'(v);
      tx  = 8'(v * 29 + 8'h5A);
      ptx = 8'(~(v * 53)) ^ 8'h3C;
      peer_en = 0;
      wr_reg(2'd0, {1'b1, 1'b1, dord, 1'b1, cpol, cpha, r});
      wr_reg(2'd1, {7'b0, fast});
      arm_peer(cpha, dord, ptx, half_of(fast, r));
      wr_reg(2'd2, tx);
      wait_irq(4000);
      peer_en = 0;
      chk("R7 done", irq_o, 1'b1);
      chk("R5 edge count", pe, 16);
      chk("R6 edge spacing", bad_gap, 0);
      chk("R4 shifted out", peer_rx, tx);
      chk("R5 rest level", sck_o, cpol);
      rd_reg(2'd2, d); chk("R7 received", d, ptx);
      chk("R11 no clear", irq_o, 1'b1);
      rd_reg(2'd1, d); chk("R3 flag set", d, {7'h40, fast});
      rd_reg(2'd2, d);
      chk("R11 cleared", irq_o, 1'b0);
      rd_reg(2'd1, d); chk("R11 stat clear", d, {7'h00, fast});
    end
    wr_reg(2'd1, 8'h00);

    // R10 collision keeps the byte in flight
    wr_reg(2'd0, 8'hD3);
    arm_peer(1'b0, 1'b0, 8'h96, 64);
    wr_reg(2'd2, 8'hC4);
    wait_cyc(200);
    wr_reg(2'd2, 8'h3B);
    wait_irq(4000);
    peer_en = 0;
    chk("R10 byte intact", peer_rx, 8'hC4);
    rd_reg(2'd1, d); chk("R10 collision flag", d, 8'hC0);
    rd_reg(2'd2, d); chk("R10 rx", d, 8'h96);
    rd_reg(2'd1, d); chk("R11 both clear", d, 8'h00);

    // R8 irq gating and acknowledge
    wr_reg(2'd0, 8'h54);
    wr_reg(2'd1, 8'h01);
    arm_peer(1'b0, 1'b0, 8'h11, 1);
    wr_reg(2'd2, 8'h22);
    wait_cyc(40);
    peer_en = 0;
    chk("R8 irq masked", irq_o, 1'b0);
    wr_reg(2'd0, 8'hD4);
    chk("R8 irq enabled", irq_o, 1'b1);
    @(negedge clk_i); irq_ack_i = 1'b1;
    @(negedge clk_i); irq_ack_i = 1'b0;
    chk("R8 ack", irq_o, 1'b0);
    rd_reg(2'd1, d); chk("R8 stat after ack", d, 8'h01);
    wr_reg(2'd1, 8'h00);

    // R9 mode fault
    wr_reg(2'd0, 8'hD0);
    ss_ni = 1'b0;
    wait_cyc(4);
    rd_reg(2'd0, d); chk("R9 master cleared", d, 8'hC0);
    chk("R9 irq", irq_o, 1'b1);
    rd_reg(2'd1, d); chk("R9 flag", d, 8'h80);
    rd_reg(2'd2, d);
    ss_ni = 1'b1;
    wait_cyc(4);
    rd_reg(2'd1, d); chk("R9 cleared", d, 8'h00);

    // R12 slave mode in all clock modes and orders
    for (int v = 0; v < 8; v++) begin
      logic cpol, cpha, dord;
      logic [7:0] stx, mtx;
      {dord, cpha, cpol} = 3'(v);
      stx = 8'(v * 37 + 8'h69);
      mtx = 8'(v * 71 + 8'h1E);
      ss_ni = 1'b1; sck_i = cpol;
      wr_reg(2'd0, {1'b1, 1'b1, dord, 1'b0, cpol, cpha, 2'b11});
      wait_cyc(4);
      chk("R12 released", miso_oe_o, 1'b0);
      wr_reg(2'd2, stx);
      if (v == 5) begin
        ss_ni = 1'b0; wait_cyc(4);
        slave_xfer(cpol, cpha, dord, 8'hFF, 3, mrx);
        ss_ni = 1'b1; wait_cyc(4);
        chk("R12 partial no flag", irq_o, 1'b0);
        wr_reg(2'd2, stx);
      end
      ss_ni = 1'b0; wait_cyc(4);
      chk("R12 driven", miso_oe_o, 1'b1);
      slave_xfer(cpol, cpha, dord, mtx, 8, mrx);
      wait_cyc(4);
      chk("R12 done", irq_o, 1'b1);
      chk("R12 slave out", mrx, stx);
      rd_reg(2'd2, d); chk("R12 slave in", d, mtx);
      rd_reg(2'd1, d);
      rd_reg(2'd2, d);
      chk("R12 flag clear", irq_o, 1'b0);
      ss_ni = 1'b1; wait_cyc(4);
      chk("R12 release after", miso_oe_o, 1'b0);
    end

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk_i);
    if (!done_flag) begin
      vectors++;
      misses++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule